// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data-enable, the pixel coordinates inside the visible area, and a one-cycle pulse when the last visible line of a frame has been scanned. The pulse is meant as the source of a vertical-blanking interrupt. One clock cycle is one pixel.

All geometry arrives as four 32-bit words, each carrying two 16-bit fields. The fields use a mixed encoding: every length is stored as its count minus one, except the vertical back porch, which is stored as its plain count and may therefore be zero. Two polarity inputs select active-low syncs. The words and polarity bits are captured only at frame boundaries, so software may rewrite them at any time. A run input starts scanning from an idle state and, when dropped, lets the current frame complete before the block parks.

Top module: `lcd_timing_gen`

## Requirements
- R1: Field decoding: `cfg_sync_word` holds horizontal sync width minus one in [15:0] and vertical sync height minus one in [31:16]; `cfg_vporch_word` holds vertical front porch minus one in [15:0] and the vertical back porch as its true line count in [31:16]; `cfg_hporch_word` holds horizontal front porch minus one in [15:0] and horizontal back porch minus one in [31:16]; `cfg_active_word` holds visible pixels per line minus one in [15:0] and visible lines per frame minus one in [31:16].
- R2: Each line lasts sync + back porch + visible + front porch pixel cycles, in that order; the horizontal sync is active during the first sync-width cycles of every line.
- R3: Each frame lasts sync + back porch + visible + front porch lines, in that order; the vertical sync is active during every cycle of the first sync-height lines.
- R4: When `hsync_low` (`vsync_low`) is 1 the corresponding sync output is active-low; when 0 it is active-high.
- R5: `de` is 1 exactly when the horizontal position is inside the visible pixels and the vertical position is inside the visible lines.
- R6: While `de` is 1, `pix_x` and `pix_y` give the offset from the first visible pixel and first visible line; while `de` is 0 both are 0.
- R7: The configuration words and polarity inputs are captured when scanning starts and at each frame wrap; changes made at any other time while scanning have no effect on the current frame.
- R8: `frame_done` is 1 for exactly one cycle per frame: the last pixel cycle of the last visible line.
- R9: When `run` is 0 at the last cycle of a frame, scanning stops; while stopped `de`, `frame_done`, `pix_x` and `pix_y` are 0 and both syncs sit at their inactive level for the current polarity inputs.
- R10: When `run` is 1 while stopped, the next cycle is the first pixel of line 0 of a new frame (horizontal and vertical sync active).
- R11: A synchronous active-high `rst` puts the block in the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start / keep scanning |
| cfg_sync_word | input | 32 | Sync widths (both minus one) |
| cfg_vporch_word | input | 32 | Vertical front porch minus one, vertical back porch true count |
| cfg_hporch_word | input | 32 | Horizontal front and back porch, minus one |
| cfg_active_word | input | 32 | Visible pixels and lines, minus one |
| hsync_low | input | 1 | Horizontal sync active-low when 1 |
| vsync_low | input | 1 | Vertical sync active-low when 1 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Visible pixel offset |
| pix_y | output | 16 | Visible line offset |
| frame_done | output | 1 | End of last visible line pulse |

## Verification
The block is built with its default 16-bit fields, but the bench programs only small lengths: every combination of two values for each of the eight timing lengths (256 geometries, including a vertical back porch of zero) with polarities that vary across the sweep. Small lengths keep each frame under a hundred cycles, so every pixel of every frame is compared against positions computed arithmetically from the cycle count. Each geometry is scanned back to back with a second one written mid-frame, and run is dropped mid-frame, which brings frame-boundary capture, stopping and restarting within reach for all of them.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int CNT_W   = FIELD_W + 3;

    // true lengths of the four regions of one axis
    typedef struct packed {
        logic [CNT_W-1:0] sync_len;
        logic [CNT_W-1:0] back_len;
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] front_len;
    } span_t;

    typedef struct packed {
        span_t h;
        span_t v;
        logic  h_low;
        logic  v_low;
    } timing_t;

    typedef enum logic {SC_IDLE, SC_RUN} scan_state_t;

    function automatic logic [CNT_W-1:0] as_count(input logic [FIELD_W-1:0] f);
        return CNT_W'(f);
    endfunction

    function automatic logic [CNT_W-1:0] plus_one(input logic [FIELD_W-1:0] f);
        return CNT_W'(f) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] span_total(input span_t s);
        return s.sync_len + s.back_len + s.act_len + s.front_len;
    endfunction

    function automatic timing_t decode_words(
        input logic [WORD_W-1:0] w_sync,
        input logic [WORD_W-1:0] w_vpor,
        input logic [WORD_W-1:0] w_hpor,
        input logic [WORD_W-1:0] w_act,
        input logic              h_low,
        input logic              v_low
    );
        timing_t t;
        t.h.sync_len  = plus_one(w_sync[FIELD_W-1:0]);
        t.v.sync_len  = plus_one(w_sync[WORD_W-1:FIELD_W]);
        t.v.front_len = plus_one(w_vpor[FIELD_W-1:0]);
        t.v.back_len  = as_count(w_vpor[WORD_W-1:FIELD_W]);
        t.h.front_len = plus_one(w_hpor[FIELD_W-1:0]);
        t.h.back_len  = plus_one(w_hpor[WORD_W-1:FIELD_W]);
        t.h.act_len   = plus_one(w_act[FIELD_W-1:0]);
        t.v.act_len   = plus_one(w_act[WORD_W-1:FIELD_W]);
        t.h_low       = h_low;
        t.v_low       = v_low;
        return t;
    endfunction

endpackage

// File: rtl/lcdt_cfg_latch.sv
module lcdt_cfg_latch
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              load,
    input  logic [WORD_W-1:0] w_sync,
    input  logic [WORD_W-1:0] w_vpor,
    input  logic [WORD_W-1:0] w_hpor,
    input  logic [WORD_W-1:0] w_act,
    input  logic              h_low,
    input  logic              v_low,
    output timing_t           cfg_q
);

    // data register: loaded during reset, idle and at every frame wrap
    always_ff @(posedge clk) begin
        if (load) begin
            cfg_q <= decode_words(w_sync, w_vpor, w_hpor, w_act, h_low, v_low);
        end
    end

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic             running,
    output logic             line_end,
    output logic             frame_wrap,
    output logic [CNT_W-1:0] hpos,
    output logic [CNT_W-1:0] vpos
);

    scan_state_t st;
    logic        v_last;

    assign running    = (st == SC_RUN);
    assign line_end   = running && (hpos == h_total - CNT_W'(1));
    assign v_last     = (vpos == v_total - CNT_W'(1));
    assign frame_wrap = line_end && v_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SC_IDLE;
            hpos <= '0;
            vpos <= '0;
        end else begin
            case (st)
                SC_IDLE: begin
                    if (run) st <= SC_RUN;
                end
                default: begin
                    if (line_end) begin
                        hpos <= '0;
                        if (v_last) begin
                            vpos <= '0;
                            if (!run) st <= SC_IDLE;
                        end else begin
                            vpos <= vpos + CNT_W'(1);
                        end
                    end else begin
                        hpos <= hpos + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    p_idle_at_origin_r9: assert property (@(posedge clk) disable iff (rst)
        !running |-> (hpos == '0 && vpos == '0));

    p_pixel_step_r2: assert property (@(posedge clk) disable iff (rst)
        (running && !line_end) |=> (hpos == $past(hpos) + CNT_W'(1)));

    p_line_restart_r2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (hpos == '0));

    p_stop_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_wrap && !run) |=> !running);

endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
(
    input  logic [CNT_W-1:0]   pos,
    input  span_t              sp,
    output logic               in_sync,
    output logic               in_act,
    output logic               last_act,
    output logic [FIELD_W-1:0] offset
);

    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_stop;

    assign act_start = sp.sync_len + sp.back_len;
    assign act_stop  = act_start + sp.act_len;

    always_comb begin
        in_sync  = (pos < sp.sync_len);
        in_act   = (pos >= act_start) && (pos < act_stop);
        last_act = (pos == act_stop - CNT_W'(1));
        offset   = in_act ? FIELD_W'(pos - act_start) : '0;
    end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [WORD_W-1:0]  cfg_sync_word,
    input  logic [WORD_W-1:0]  cfg_vporch_word,
    input  logic [WORD_W-1:0]  cfg_hporch_word,
    input  logic [WORD_W-1:0]  cfg_active_word,
    input  logic               hsync_low,
    input  logic               vsync_low,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [FIELD_W-1:0] pix_x,
    output logic [FIELD_W-1:0] pix_y,
    output logic               frame_done
);

    localparam int N_AXES = 2;   // index 0 horizontal, 1 vertical

    timing_t          cfg_q;
    logic             load;
    logic             running;
    logic             line_end;
    logic             frame_wrap;
    logic [CNT_W-1:0] hpos, vpos;

    logic [CNT_W-1:0]   ax_pos   [N_AXES];
    span_t              ax_span  [N_AXES];
    logic               ax_sync  [N_AXES];
    logic               ax_act   [N_AXES];
    logic               ax_last  [N_AXES];
    logic [FIELD_W-1:0] ax_off   [N_AXES];

    assign load = rst || !running || frame_wrap;

    lcdt_cfg_latch u_cfg (
        .clk    (clk),
        .load   (load),
        .w_sync (cfg_sync_word),
        .w_vpor (cfg_vporch_word),
        .w_hpor (cfg_hporch_word),
        .w_act  (cfg_active_word),
        .h_low  (hsync_low),
        .v_low  (vsync_low),
        .cfg_q  (cfg_q)
    );

    lcdt_scan u_scan (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .h_total    (span_total(cfg_q.h)),
        .v_total    (span_total(cfg_q.v)),
        .running    (running),
        .line_end   (line_end),
        .frame_wrap (frame_wrap),
        .hpos       (hpos),
        .vpos       (vpos)
    );

    assign ax_pos[0]  = hpos;
    assign ax_pos[1]  = vpos;
    assign ax_span[0] = cfg_q.h;
    assign ax_span[1] = cfg_q.v;

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        lcdt_axis u_axis (
            .pos      (ax_pos[a]),
            .sp       (ax_span[a]),
            .in_sync  (ax_sync[a]),
            .in_act   (ax_act[a]),
            .last_act (ax_last[a]),
            .offset   (ax_off[a])
        );
    end

    always_comb begin
        de         = running && ax_act[0] && ax_act[1];
        hsync      = (running && ax_sync[0]) ^ cfg_q.h_low;
        vsync      = (running && ax_sync[1]) ^ cfg_q.v_low;
        pix_x      = de ? ax_off[0] : '0;
        pix_y      = de ? ax_off[1] : '0;
        frame_done = line_end && ax_last[1];
    end

    p_de_needs_scan_r5: assert property (@(posedge clk) disable iff (rst)
        de |-> running);

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && !$past(frame_wrap)) |-> $stable(cfg_q));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !de));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!de && !frame_done && pix_x == '0 && pix_y == '0));

endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [31:0] w_sync, w_vpor, w_hpor, w_act;
    logic        hlow = 1'b0, vlow = 1'b0;
    logic        hsync, vsync, de, frame_done;
    logic [15:0] pix_x, pix_y;

    always #2 clk = ~clk;   // 250 MHz

    lcd_timing_gen u0 (
        .clk(clk), .rst(rst), .run(run),
        .cfg_sync_word(w_sync), .cfg_vporch_word(w_vpor),
        .cfg_hporch_word(w_hpor), .cfg_active_word(w_act),
        .hsync_low(hlow), .vsync_low(vlow),
        .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .frame_done(frame_done)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // values driven on the inputs (true counts)
    int i_hsw, i_hbp, i_hact, i_hfp, i_vsw, i_vbp, i_vact, i_vfp, i_hl, i_vl;
    // values the model holds for the frame in progress
    int c_hsw, c_hbp, c_hact, c_hfp, c_vsw, c_vbp, c_vact, c_vfp, c_hl, c_vl;
    int m_run = 0;
    int m_n   = 0;

    // R1: field packing, each length minus one except vertical back porch
    task automatic drive(input int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, hl, vl);
        i_hsw = hsw; i_hbp = hbp; i_hact = hact; i_hfp = hfp;
        i_vsw = vsw; i_vbp = vbp; i_vact = vact; i_vfp = vfp;
        i_hl = hl; i_vl = vl;
        w_sync = {16'(vsw - 1), 16'(hsw - 1)};
        w_vpor = {16'(vbp),     16'(vfp - 1)};
        w_hpor = {16'(hbp - 1), 16'(hfp - 1)};
        w_act  = {16'(vact - 1), 16'(hact - 1)};
        hlow = 1'(hl);
        vlow = 1'(vl);
    endtask

    task automatic capture();
        c_hsw = i_hsw; c_hbp = i_hbp; c_hact = i_hact; c_hfp = i_hfp;
        c_vsw = i_vsw; c_vbp = i_vbp; c_vact = i_vact; c_vfp = i_vfp;
        c_hl = i_hl; c_vl = i_vl;
    endtask

    function automatic int line_len();
        return c_hsw + c_hbp + c_hact + c_hfp;
    endfunction

    function automatic int frame_len();
        return line_len() * (c_vsw + c_vbp + c_vact + c_vfp);
    endfunction

    task automatic fail(input string req, input string what, input int act, input int exp);
        $display("FAIL %s %s: actual %0d expected %0d (frame cycle %0d)", req, what, act, exp, m_n);
    endtask

    task automatic check();
        int h, v, hs0, vs0, e_hs, e_vs, e_de, e_px, e_py, e_fd;
        bit bad;
        string rq;
        bad = 0;
        h = m_n % line_len();
        v = m_n / line_len();
        hs0 = c_hsw + c_hbp;
        vs0 = c_vsw + c_vbp;
        if (m_run != 0) begin
            rq   = "R1/R7/R10";
            e_hs = int'(h < c_hsw) ^ c_hl;
            e_vs = int'(v < c_vsw) ^ c_vl;
            e_de = int'(h >= hs0 && h < hs0 + c_hact && v >= vs0 && v < vs0 + c_vact);
            e_px = e_de ? h - hs0 : 0;
            e_py = e_de ? v - vs0 : 0;
            e_fd = int'(h == line_len() - 1 && v == vs0 + c_vact - 1);
        end else begin
            rq   = "R9/R11";
            e_hs = c_hl; e_vs = c_vl;
            e_de = 0; e_px = 0; e_py = 0; e_fd = 0;
        end
        n_vec++;
        if (int'(hsync) != e_hs)      begin bad = 1; fail({rq, " R2 R4"}, "hsync", int'(hsync), e_hs); end
        if (int'(vsync) != e_vs)      begin bad = 1; fail({rq, " R3 R4"}, "vsync", int'(vsync), e_vs); end
        if (int'(de) != e_de)         begin bad = 1; fail({rq, " R5"}, "de", int'(de), e_de); end
        if (int'(pix_x) != e_px)      begin bad = 1; fail({rq, " R6"}, "pix_x", int'(pix_x), e_px); end
        if (int'(pix_y) != e_py)      begin bad = 1; fail({rq, " R6"}, "pix_y", int'(pix_y), e_py); end
        if (int'(frame_done) != e_fd) begin bad = 1; fail({rq, " R8"}, "frame_done", int'(frame_done), e_fd); end
        if (bad) n_bad++;
    endtask

    // one clock: advance the model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_run = 0; m_n = 0; capture();
        end else if (m_run == 0) begin
            capture();                       // R10: start captures the words
            if (run) begin m_run = 1; m_n = 0; end
        end else begin
            m_n++;
            if (m_n == frame_len()) begin    // R7: capture only at the wrap
                m_n = 0;
                capture();
                if (!run) m_run = 0;         // R9: stop after finishing
            end
        end
        @(negedge clk);
        check();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int la, lb, half;
        drive(2, 2, 3, 1, 1, 1, 2, 1, 1, 0);
        // R11: reset state
        repeat (2) tick();
        @(negedge clk);
        rst = 1'b0;
        repeat (3) tick();

        for (int c = 0; c < 256; c++) begin
            int a_hsw, a_hbp, a_hact, a_hfp, a_vsw, a_vbp, a_vact, a_vfp, a_hl, a_vl;
            a_hsw = 1 + c[0];     a_hbp = 1 + 2 * c[1];
            a_hact = 1 + 3 * c[2]; a_hfp = 1 + c[3];
            a_vsw = 1 + c[4];     a_vbp = c[5];
            a_vact = 1 + 2 * c[6]; a_vfp = 1 + c[7];
            a_hl = c[0] ^ c[3] ^ c[6];
            a_vl = c[1] ^ c[5] ^ c[7];

            // R9: stopped with the new polarity, syncs inactive
            run = 1'b0;
            drive(a_hsw, a_hbp, a_hact, a_hfp, a_vsw, a_vbp, a_vact, a_vfp, a_hl, a_vl);
            repeat (3) tick();

            // R10: start a frame with geometry A
            run = 1'b1;
            la = (a_hsw + a_hbp + a_hact + a_hfp) * (a_vsw + a_vbp + a_vact + a_vfp);
            half = la / 2;
            for (int k = 0; k < 1 + la; k++) begin
                tick();
                // R7: rewrite every word mid-frame; A must continue
                if (k == half)
                    drive(2, 1, 3, 1 + (c % 2), 1, c % 3, 2, 1, 1 - a_hl, 1 - a_vl);
            end

            // geometry B now scanning; drop run mid-frame and rewrite again
            lb = (2 + 1 + 3 + 1 + (c % 2)) * (1 + (c % 3) + 2 + 1);
            for (int k = 0; k < lb / 2; k++) tick();
            run = 1'b0;
            drive(a_hsw, a_hbp, a_hact, a_hfp, a_vsw, a_vbp, a_vact, a_vfp, a_hl, a_vl);
            for (int k = 0; k < lb - lb / 2 + 3; k++) tick();
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule